// File: doc/BRIEF.md
# Multi-Rail Supervisor Reset Sequencer

This block is the digital core of a supervisor that watches several supply rails. Comparators outside the block turn each rail into an "undervoltage" flag, one bit per rail, already in the block's clock domain. For each rail the block drives a status output that follows that rail's flag with no delay. It also drives one combined active-low reset. Any rail fault or a manual reset request pulls this reset low. The reset is held low for a timeout after every cause has gone away.

The timeout is counted in ticks of a one-cycle enable input, so a slow time base such as 1 ms maps onto the clock. A parameter selects the source of the tick count. One choice is a fixed internal value, which defaults to 140 ticks, or 140 ms at a 1 ms tick. The other is a count supplied on an input port. An active-low margin input overrides everything and forces all outputs high. This lets the rails be pushed out of range during margin testing without tripping the system.

Top module: `rail_supervisor`

## Requirements
- R1: With `marginN` high, `railStatus[i]` is 0 in the same cycle that `railLow[i]` is 1, and is 1 in the same cycle that `railLow[i]` is 0. There is no register on this path.
- R2: When any `railLow` bit is 1 at a rising clock edge, `resetN` is 0 after that edge (one clock of latency).
- R3: `mrN` passes through a two-flop synchronizer. `resetN` goes low after the third rising edge at which `mrN` is low. When `mrN` returns high with all rails good, the timeout starts at the third rising edge after the release. `mrN` has no effect on `railStatus`.
- R4: Once every cause of reset has cleared, `resetN` stays low and goes high at the rising edge that consumes the T-th tick. T is the timeout length. Ticks are counted from the first fault-free edge, which only clears the counter and consumes no tick.
- R5: A fault or a manual reset during the countdown returns the count to zero. After the cause clears, a full timeout of T ticks runs again.
- R6: The countdown advances only at edges where `tickEn` is 1. With `tickEn` held at 0, `resetN` stays low indefinitely.
- R7: While `marginN` is 0, every `railStatus` bit and `resetN` are 1 in the same cycle, whatever `railLow` and `mrN` are.
- R8: While `rstN` is low, `resetN` is 0. After `rstN` is released, a full timeout of T ticks runs before `resetN` goes high.
- R9: With `USE_EXT_TIMEOUT`=1, T equals `progTimeout`, and a value of 0 acts as 1. With `USE_EXT_TIMEOUT`=0, T equals `FIXED_TIMEOUT` (default 140), and `progTimeout` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low logic reset |
| tickEn | input | 1 | One-cycle time-base tick for the timeout counter |
| railLow | input | NUM_RAILS | Per-rail undervoltage flag, 1 = below threshold |
| mrN | input | 1 | Active-low manual reset request, asynchronous |
| marginN | input | 1 | Active-low margin override, forces all outputs high |
| progTimeout | input | CNT_W | Timeout in ticks, used when USE_EXT_TIMEOUT=1 |
| railStatus | output | NUM_RAILS | Per-rail status, 0 = rail below threshold |
| resetN | output | 1 | Combined active-low reset |

## Verification
Suppose the sequencer's state or counter went wrong. It would show up only on `resetN`, and only at a release edge. The bench therefore samples `resetN` at the exact edge of the last tick and at the edge before it, so an off-by-one count is caught at once. A counter that is not cleared on a mid-count fault would release early in the restart test, within T cycles. A per-rail status bit swapped or latched shows up in the same cycle that its flag changes. A synchronizer stage too many or too few moves the `mrN` assertion edge by one clock.

// File: rtl/rail_sup_pkg.sv
package rail_sup_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } supState_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } cntStrobe_t;
endpackage

// File: rtl/rail_sup_ctrl.sv
module rail_sup_ctrl
  import rail_sup_pkg::*;
#(
  parameter int NUM_RAILS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic [NUM_RAILS-1:0] railLow,
  input  logic                 mrN,
  input  logic                 cntDone,
  output cntStrobe_t           strobe,
  output logic                 releaseOk
);
  logic mrMeta;
  logic mrSync;
  logic anyFault;
  supState_t state;
  supState_t nextState;

  // two-flop synchronizer for the asynchronous manual reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mrMeta <= 1'b1;
      mrSync <= 1'b1;
    end else begin
      mrMeta <= mrN;
      mrSync <= mrMeta;
    end
  end

  assign anyFault = (|railLow) | ~mrSync;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (anyFault) begin
      nextState       = ST_HOLD;
      strobe.cntClear = 1'b1;
    end else begin
      case (state)
        ST_HOLD: begin
          nextState       = ST_COUNT;
          strobe.cntClear = 1'b1;
        end
        ST_COUNT: begin
          if (tickEn) begin
            if (cntDone) nextState = ST_RUN;
            else         strobe.cntInc = 1'b1;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  // power-on starts in the countdown so a full timeout runs first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_COUNT;
    else       state <= nextState;
  end

  assign releaseOk = (state == ST_RUN);
endmodule

// File: rtl/rail_sup_datapath.sv
module rail_sup_datapath
  import rail_sup_pkg::*;
#(
  parameter int NUM_RAILS       = 4,
  parameter int CNT_W           = 16,
  parameter bit USE_EXT_TIMEOUT = 1'b0,
  parameter int FIXED_TIMEOUT   = 140
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cntStrobe_t           strobe,
  input  logic [NUM_RAILS-1:0] railLow,
  input  logic                 marginN,
  input  logic [CNT_W-1:0]     progTimeout,
  input  logic                 releaseOk,
  output logic                 cntDone,
  output logic [NUM_RAILS-1:0] railStatus,
  output logic                 resetN
);
  localparam logic [CNT_W-1:0] FIXED_LIMIT = CNT_W'(FIXED_TIMEOUT);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] limitVal;
  logic [CNT_W:0]   cntNext;

  assign limitVal = USE_EXT_TIMEOUT ? progTimeout : FIXED_LIMIT;
  assign cntNext  = {1'b0, tickCnt} + {{CNT_W{1'b0}}, 1'b1};
  assign cntDone  = (cntNext >= {1'b0, limitVal});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               tickCnt <= '0;
    else if (strobe.cntClear) tickCnt <= '0;
    else if (strobe.cntInc)   tickCnt <= cntNext[CNT_W-1:0];
  end

  for (genvar gi = 0; gi < NUM_RAILS; gi++) begin : g_rail
    assign railStatus[gi] = ~railLow[gi] | ~marginN;
  end

  assign resetN = releaseOk | ~marginN;
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import rail_sup_pkg::*;
#(
  parameter int NUM_RAILS       = 4,
  parameter int CNT_W           = 16,
  parameter bit USE_EXT_TIMEOUT = 1'b0,
  parameter int FIXED_TIMEOUT   = 140
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic [NUM_RAILS-1:0] railLow,
  input  logic                 mrN,
  input  logic                 marginN,
  input  logic [CNT_W-1:0]     progTimeout,
  output logic [NUM_RAILS-1:0] railStatus,
  output logic                 resetN
);
  cntStrobe_t strobe;
  logic       cntDone;
  logic       releaseOk;

  rail_sup_ctrl #(.NUM_RAILS(NUM_RAILS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .railLow   (railLow),
    .mrN       (mrN),
    .cntDone   (cntDone),
    .strobe    (strobe),
    .releaseOk (releaseOk)
  );

  rail_sup_datapath #(
    .NUM_RAILS       (NUM_RAILS),
    .CNT_W           (CNT_W),
    .USE_EXT_TIMEOUT (USE_EXT_TIMEOUT),
    .FIXED_TIMEOUT   (FIXED_TIMEOUT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .railLow     (railLow),
    .marginN     (marginN),
    .progTimeout (progTimeout),
    .releaseOk   (releaseOk),
    .cntDone     (cntDone),
    .railStatus  (railStatus),
    .resetN      (resetN)
  );
endmodule

// File: rtl/rail_sup_checker.sv
module rail_sup_checker #(
  parameter int NUM_RAILS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tickEn,
  input logic [NUM_RAILS-1:0] railLow,
  input logic                 marginN,
  input logic [NUM_RAILS-1:0] railStatus,
  input logic                 resetN
);
  assert_status_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    marginN |-> (railStatus == ~railLow));

  assert_fault_asserts_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((|railLow) && marginN) |=> (!resetN || !marginN));

  assert_release_clean_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(resetN) && marginN && $past(marginN)) |-> ($past(railLow) == '0));

  assert_release_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(resetN) && marginN && $past(marginN)) |-> $past(tickEn));

  assert_margin_forces_R7: assert property (@(posedge clk) disable iff (!rstN)
    !marginN |-> ((&railStatus) && resetN));
endmodule

bind rail_supervisor rail_sup_checker #(.NUM_RAILS(NUM_RAILS)) u_chk (.*);

// File: tb/rail_supervisor_tb.sv
module rail_supervisor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR   = 4;
  localparam int CW   = 16;
  localparam int PROG = 5;
  localparam int FIX  = 7;

  // {railLow[3:0], marginN, expected railStatus[3:0]}
  localparam logic [8:0] VEC [8] = '{
    9'b0000_1_1111, 9'b0001_1_1110, 9'b0010_1_1101, 9'b1100_1_0011,
    9'b1111_1_0000, 9'b1111_0_1111, 9'b0101_0_1111, 9'b1010_1_0101
  };

  logic clk = 1'b0;
  logic rstN, tickEn, mrN, marginN;
  logic [NR-1:0] railLow;
  logic [CW-1:0] progTimeout;
  logic [NR-1:0] railStatus, statusFix;
  logic resetN, resetFix;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  rail_supervisor #(.NUM_RAILS(NR), .CNT_W(CW), .USE_EXT_TIMEOUT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .railLow(railLow), .mrN(mrN),
    .marginN(marginN), .progTimeout(progTimeout), .railStatus(railStatus),
    .resetN(resetN));

  rail_supervisor #(.NUM_RAILS(NR), .CNT_W(CW), .USE_EXT_TIMEOUT(1'b0),
                    .FIXED_TIMEOUT(FIX)) u_dutFixed (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .railLow(railLow), .mrN(mrN),
    .marginN(marginN), .progTimeout(CW'(2)), .railStatus(statusFix),
    .resetN(resetFix));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkRst(input string req, input logic exp);
    check(resetN === exp, req, int'(resetN), int'(exp));
  endtask

  // clear a fault at the current negedge and check the release edge
  task automatic expectRelease(input string req, input int lowUntil);
    for (int k = 1; k <= lowUntil + 1; k++) begin
      @(negedge clk);
      if (k == lowUntil)     chkRst(req, 1'b0);
      if (k == lowUntil + 1) chkRst(req, 1'b1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; tickEn = 1'b1; railLow = '0; mrN = 1'b1; marginN = 1'b1;
    progTimeout = CW'(PROG);
    repeat (3) @(negedge clk);
    // R8: reset state
    chkRst("R8 resetN in reset", 1'b0);
    check(resetFix === 1'b0, "R8 fixed resetN in reset", int'(resetFix), 0);
    check(railStatus === 4'b1111, "R1 status in reset", int'(railStatus), 15);
    rstN = 1'b1;
    // R8/R9: power-on timeout, ext T=5, fixed T=7 ignoring progTimeout=2
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == PROG - 1) chkRst("R8 power-on ext before T", 1'b0);
      if (k == PROG)     chkRst("R9 power-on ext at T", 1'b1);
      if (k == FIX - 1) check(resetFix === 1'b0, "R9 fixed before T", int'(resetFix), 0);
      if (k == FIX)     check(resetFix === 1'b1, "R9 fixed at T", int'(resetFix), 1);
    end

    // R1/R7: table of rail and margin patterns
    foreach (VEC[i]) begin
      railLow = VEC[i][8:5]; marginN = VEC[i][4];
      #1;
      check(railStatus === VEC[i][3:0], marginN ? "R1 status pattern" : "R7 margin status",
            int'(railStatus), int'(VEC[i][3:0]));
      if (!marginN) chkRst("R7 margin forces resetN", 1'b1);
      @(negedge clk);
    end
    railLow = '0; marginN = 1'b1;
    repeat (12) @(negedge clk);
    chkRst("R4 released after table", 1'b1);

    // R2: single rail fault, one clock of latency
    railLow = 4'b0100;
    #1;
    chkRst("R2 no change before edge", 1'b1);
    check(railStatus === 4'b1011, "R1 rail 2 low", int'(railStatus), 11);
    @(negedge clk);
    chkRst("R2 fault asserts resetN", 1'b0);
    railLow = '0;
    expectRelease("R4 timeout after rail clear", PROG);

    // R5: fault mid-count restarts
    railLow = 4'b0001;
    @(negedge clk);
    railLow = '0;
    repeat (3) @(negedge clk);
    chkRst("R5 still counting", 1'b0);
    railLow = 4'b1000;
    @(negedge clk);
    railLow = '0;
    expectRelease("R5 full restart", PROG);

    // R3: manual reset through synchronizer
    mrN = 1'b0;
    @(negedge clk); @(negedge clk);
    chkRst("R3 not yet asserted", 1'b1);
    @(negedge clk);
    chkRst("R3 asserted on third edge", 1'b0);
    check(railStatus === 4'b1111, "R3 status unaffected", int'(railStatus), 15);
    mrN = 1'b1;
    expectRelease("R3 release timeout", PROG + 2);

    // R6: no ticks, no progress
    tickEn = 1'b0;
    railLow = 4'b0010;
    @(negedge clk);
    railLow = '0;
    repeat (20) @(negedge clk);
    chkRst("R6 held without ticks", 1'b0);
    for (int p = 1; p <= PROG; p++) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
      if (p == PROG - 1) chkRst("R6 one tick short", 1'b0);
      if (p == PROG)     chkRst("R6 released on last tick", 1'b1);
    end
    tickEn = 1'b1;

    // R9: programmed zero acts as one
    progTimeout = '0;
    railLow = 4'b0001;
    @(negedge clk);
    railLow = '0;
    expectRelease("R9 zero timeout", 1);

    // R7: margin during fault, then fault seen when margin released
    railLow = 4'b1111; marginN = 1'b0;
    #1;
    chkRst("R7 margin with faults", 1'b1);
    @(negedge clk);
    chkRst("R7 margin held over edge", 1'b1);
    marginN = 1'b1;
    #1;
    chkRst("R2 fault visible after margin", 1'b0);
    railLow = '0;

    finished = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule